// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM

This block is a clocked model of a synchronous static RAM. Its data bus never needs an idle cycle when traffic switches between reads and writes. On every rising clock edge where the clock enable is high, it captures a command. The command is made of an address, a read/write select, per-lane byte-write enables and three chip enables. Write data is not presented with its command. It follows later on a separate input, and the model keeps the write address and lane mask until that data arrives. Because of this, the bus slot a write leaves behind can carry read data from an earlier read.

The `PIPELINED` parameter selects one of two read paths.
- **Pipelined:** read data passes through an output register, and write data trails its command by two accepted edges.
- **Flow-through:** read data comes straight from the array after the command edge, and write data trails by one accepted edge.

A low clock enable freezes everything. An asynchronous output enable can switch the drivers off at any moment. An asynchronous sleep input makes the model drop the commands that arrive while it is high. In pipelined mode, a read that hits a write whose data is being captured on the same edge gets the new data, merged per byte lane over the stored word.

Top module: `nowait_sram`

## Requirements
- R1: After reset is released, `dq_oe` stays low until a read command has been accepted and its data slot has come.
- R2: With `PIPELINED`=1, a read accepted at an enabled edge n puts the word on `dq_out` with `dq_oe` high after enabled edge n+1, which is two cycles of latency.
- R3: With `PIPELINED`=0, a read accepted at edge n puts the word on `dq_out` with `dq_oe` high during the cycle that follows edge n.
- R4: Write data on `dq_in` is captured at the second enabled edge after its command with `PIPELINED`=1, and at the first enabled edge after it with `PIPELINED`=0.
- R5: Reads and writes may be accepted on consecutive enabled edges in any order, with no deselect between them, and every read returns the contents left by all earlier writes.
- R6: `byte_we_n[i]` low writes lane i, which is bits [9i+8:9i]. Any subset of lanes may be written, and with all bits high the write changes nothing.
- R7: A command counts only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. If any of the three is inactive, the edge is a deselect: nothing is written and the slot is not driven.
- R8: While `clk_en` is low, the command inputs are ignored, no pending write is completed, and `dq_out` and the drive state stay as they were.
- R9: `oe_n` high forces `dq_oe` low at once, with no clock edge needed, whatever the synchronous state. `oe_n` low lets `dq_oe` follow that state.
- R10: A command sampled while `sleep` is high is ignored. It does not write and does not drive its slot.
- R11: With `PIPELINED`=1, a read accepted one edge after a write to the same address returns the new data in the written lanes and the old contents in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low holds all state |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| we_n | input | 1 | Command select: 1 read, 0 write |
| byte_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Output drive; low means the data bus is high impedance |

## Verification
The bench drives one command stream into a pipelined instance and a flow-through instance. For each instance it places write data one or two enabled edges after the command, and it keeps a separate reference array for each. After every enabled edge, at the following falling edge, it expects the flow-through outputs to show the read accepted at that edge and the pipelined outputs to show the read accepted one enabled edge earlier, with any write completed at that same edge already merged in. Hold cycles leave both the expected and the actual values unchanged. The output-enable check is taken within a fraction of a cycle, with no edge in between.

// File: rtl/nowait_sram_pkg.sv
`timescale 1ns/1ps
package nowait_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/nowait_sram_array.sv
`timescale 1ns/1ps
module nowait_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_lane,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/nowait_sram_ctrl.sv
`timescale 1ns/1ps
module nowait_sram_ctrl
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LANES     = 2,
    parameter int LANE_W    = 9,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic                      cmd_go,
    input  logic                      cmd_wr,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [LANES-1:0]          cmd_lanes,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES*LANE_W-1:0]   arr_rdata,
    output logic                      arr_wen,
    output logic [ADDR_W-1:0]         arr_waddr,
    output logic [LANES-1:0]          arr_wlane,
    output logic [ADDR_W-1:0]         arr_raddr,
    output logic [LANES*LANE_W-1:0]   out_data,
    output logic                      out_drive
);
    localparam int W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } cmd_t;

    typedef struct packed {
        cmd_t         c1;     // command from the last enabled edge
        cmd_t         c2;     // command from the edge before that
        logic [W-1:0] rd;     // output register (pipelined path)
        logic         drv;
    } state_t;

    state_t       st_q, st_d;
    cmd_t         new_cmd, wcmd;
    logic [W-1:0] merged;

    always_comb begin
        new_cmd.op    = !cmd_go ? OP_IDLE : (cmd_wr ? OP_WRITE : OP_READ);
        new_cmd.addr  = cmd_addr;
        new_cmd.lanes = cmd_lanes;
    end

    // The write whose data is on wdata now: two edges old or one edge old
    assign wcmd      = PIPELINED ? st_q.c2 : st_q.c1;
    assign arr_wen   = clk_en && (wcmd.op == OP_WRITE);
    assign arr_waddr = wcmd.addr;
    assign arr_wlane = wcmd.lanes;
    assign arr_raddr = st_q.c1.addr;

    // Forward lanes written on this same edge into the output register
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] =
            (arr_wen && arr_wlane[g] && (arr_waddr == arr_raddr))
                ? wdata[g*LANE_W +: LANE_W]
                : arr_rdata[g*LANE_W +: LANE_W];
    end

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.c1  = new_cmd;
            st_d.c2  = st_q.c1;
            st_d.rd  = merged;
            st_d.drv = (st_q.c1.op == OP_READ);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = PIPELINED ? st_q.rd  : arr_rdata;
    assign out_drive = PIPELINED ? st_q.drv : (st_q.c1.op == OP_READ);
endmodule

// File: rtl/nowait_sram.sv
`timescale 1ns/1ps
module nowait_sram #(
    parameter int ADDR_W    = 8,
    parameter int LANES     = 2,
    parameter int LANE_W    = 9,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic                      cs1_n,
    input  logic                      cs2,
    input  logic                      cs3_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          byte_we_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   dq_in,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_oe
);
    localparam int W = LANES * LANE_W;

    logic              go;
    logic              wen;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [LANES-1:0]  wlane;
    logic [W-1:0]      rdata;
    logic              drive;

    assign go = !cs1_n && cs2 && !cs3_n && !sleep;

    nowait_sram_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .PIPELINED(PIPELINED)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .cmd_go    (go),
        .cmd_wr    (!we_n),
        .cmd_addr  (addr),
        .cmd_lanes (~byte_we_n),
        .wdata     (dq_in),
        .arr_rdata (rdata),
        .arr_wen   (wen),
        .arr_waddr (waddr),
        .arr_wlane (wlane),
        .arr_raddr (raddr),
        .out_data  (dq_out),
        .out_drive (drive)
    );

    nowait_sram_array #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wen),
        .wr_addr (waddr),
        .wr_lane (wlane),
        .wr_data (dq_in),
        .rd_addr (raddr),
        .rd_data (rdata)
    );

    assign dq_oe = drive && !oe_n;
endmodule

// File: rtl/nowait_sram_chk.sv
`timescale 1ns/1ps
module nowait_sram_chk #(
    parameter bit PIPELINED = 1'b1,
    parameter int W         = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         cs1_n,
    input logic         cs2,
    input logic         cs3_n,
    input logic         we_n,
    input logic         oe_n,
    input logic         sleep,
    input logic [W-1:0] dq_out,
    input logic         dq_oe
);
    logic       rd_cmd, nonrd;
    logic [1:0] age;

    assign rd_cmd = clk_en && !cs1_n && cs2 && !cs3_n && !sleep && we_n;
    assign nonrd  = clk_en && !rd_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_OE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(dq_out)); // R8

    if (PIPELINED) begin : g_pipe
        AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2) && $past(nonrd, 2) && $past(clk_en) |-> !dq_oe); // R7
        AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2) && $past(rd_cmd, 2) && $past(clk_en) && !oe_n |-> dq_oe); // R2
    end else begin : g_flow
        AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd1) && $past(nonrd) |-> !dq_oe); // R7
        AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd1) && $past(rd_cmd) && !oe_n |-> dq_oe); // R3
    end
endmodule

bind nowait_sram nowait_sram_chk #(
    .PIPELINED(PIPELINED), .W(LANES*LANE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .we_n(we_n), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/nowait_sram_test.sv
`timescale 1ns/1ps
module nowait_sram_test;
    localparam int AW = 8;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int W  = LN * LW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [1:0]    op;   // 0 none, 1 read, 2 write
        logic [AW-1:0] a;
        logic [LN-1:0] ben;
        logic [W-1:0]  d;
    } bcmd_t;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
    logic cs1_n = 1'b1, cs2 = 1'b1, cs3_n = 1'b0, we_n = 1'b1;
    logic [LN-1:0] byte_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic oe_n = 1'b0, sleep = 1'b0;
    logic [W-1:0] p_din = '0, f_din = '0, p_dout, f_dout;
    logic p_oe, f_oe;

    logic [W-1:0] ref_p [DEPTH];
    logic [W-1:0] ref_f [DEPTH];
    bcmd_t p_c1 = '0, p_c2 = '0, f_c1 = '0;
    logic exp_p_oe = 1'b0, exp_f_oe = 1'b0;
    logic [W-1:0] exp_p_d = '0, exp_f_d = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nowait_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .PIPELINED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .we_n(we_n), .byte_we_n(byte_we_n), .addr(addr),
        .dq_in(p_din), .oe_n(oe_n), .sleep(sleep), .dq_out(p_dout), .dq_oe(p_oe));

    nowait_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .PIPELINED(1'b0)) uut_ft (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .we_n(we_n), .byte_we_n(byte_we_n), .addr(addr),
        .dq_in(f_din), .oe_n(oe_n), .sleep(sleep), .dq_out(f_dout), .dq_oe(f_oe));

    task automatic chk(input string tag, input string which, input logic act_oe,
                       input logic eoe, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act_oe !== eoe || (eoe && act !== exp)) begin
            fails++;
            $display("FAIL %s %s: oe=%0b data=%h, expected oe=%0b data=%h",
                     tag, which, act_oe, act, eoe, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, reference update at the rise, check at the next fall
    task automatic cyc(input string tag, input bit ce, input logic [2:0] csv, input bit wn,
                       input logic [LN-1:0] ben, input logic [AW-1:0] a,
                       input logic [W-1:0] d, input bit slp);
        bcmd_t nc;
        clk_en = ce; {cs1_n, cs2, cs3_n} = csv; we_n = wn;
        byte_we_n = ben; addr = a; sleep = slp;
        if (ce) begin
            f_din = f_c1.d;
            p_din = p_c2.d;
        end
        nc.op  = (!csv[2] && csv[1] && !csv[0] && !slp) ? (wn ? 2'd1 : 2'd2) : 2'd0;
        nc.a   = a; nc.ben = ben; nc.d = d;
        @(posedge clk);
        if (ce) begin
            if (f_c1.op == 2'd2)
                for (int g = 0; g < LN; g++)
                    if (!f_c1.ben[g]) ref_f[f_c1.a][g*LW +: LW] = f_c1.d[g*LW +: LW];
            if (p_c2.op == 2'd2)
                for (int g = 0; g < LN; g++)
                    if (!p_c2.ben[g]) ref_p[p_c2.a][g*LW +: LW] = p_c2.d[g*LW +: LW];
            exp_f_oe = (nc.op == 2'd1);
            exp_f_d  = ref_f[nc.a];
            exp_p_oe = (p_c1.op == 2'd1);
            exp_p_d  = ref_p[p_c1.a];
            p_c2 = p_c1; p_c1 = nc; f_c1 = nc;
        end
        @(negedge clk);
        sleep = 1'b0;
        chk(tag, "pipelined", p_oe, exp_p_oe, p_dout, exp_p_d);
        chk(tag, "flow", f_oe, exp_f_oe, f_dout, exp_f_d);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        cyc(tag, 1'b1, 3'b010, 1'b1, '1, a, '0, 1'b0);
    endtask
    task automatic wr(input string tag, input logic [AW-1:0] a, input logic [LN-1:0] ben,
                      input logic [W-1:0] d);
        cyc(tag, 1'b1, 3'b010, 1'b0, ben, a, d, 1'b0);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 1'b1, 3'b110, 1'b1, '1, '0, '0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "pipelined", p_oe, 1'b0, p_dout, '0);
        chk("R1", "flow", f_oe, 1'b0, f_dout, '0);
        idle("R1");
        idle("R1");
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) wr("R4", i[AW-1:0], 2'b00, W'(i * 1237 + 5));
        idle("R4"); idle("R4");
        rd("R4", 8'd0); rd("R4", 8'd1); rd("R4", 8'd255); idle("R4"); idle("R4");
    endtask

    task automatic t_reads();
        for (int i = 0; i < 8; i++) rd("R2", 8'(i * 37));
        idle("R3");
        rd("R3", 8'd77); idle("R3"); rd("R3", 8'd78); idle("R3"); idle("R3");
    endtask

    task automatic t_mixed();
        wr("R5", 8'd10, 2'b00, 18'h2_1111);
        rd("R5", 8'd20);
        wr("R5", 8'd20, 2'b00, 18'h1_2222);
        rd("R5", 8'd10);
        rd("R5", 8'd20);
        wr("R5", 8'd30, 2'b00, 18'h0_3333);
        wr("R5", 8'd31, 2'b00, 18'h3_4444);
        rd("R5", 8'd30);
        rd("R5", 8'd31);
        idle("R5"); idle("R5");
        wr("R11", 8'd40, 2'b00, 18'h2_AAAA);
        rd("R11", 8'd40);
        wr("R11", 8'd41, 2'b10, 18'h1_5555);
        rd("R11", 8'd41);
        wr("R11", 8'd42, 2'b01, 18'h3_0F0F);
        rd("R11", 8'd42);
        idle("R11"); idle("R11");
    endtask

    task automatic t_bytes();
        wr("R6", 8'd50, 2'b00, 18'h0_0000);
        wr("R6", 8'd50, 2'b10, 18'h3_FFFF);
        wr("R6", 8'd51, 2'b00, 18'h0_0000);
        wr("R6", 8'd51, 2'b01, 18'h3_FFFF);
        wr("R6", 8'd52, 2'b11, 18'h3_FFFF);
        idle("R6"); idle("R6");
        rd("R6", 8'd50); rd("R6", 8'd51); rd("R6", 8'd52);
        idle("R6"); idle("R6");
    endtask

    task automatic t_desel();
        cyc("R7", 1'b1, 3'b110, 1'b0, 2'b00, 8'd60, 18'h1_1111, 1'b0);
        cyc("R7", 1'b1, 3'b000, 1'b0, 2'b00, 8'd61, 18'h1_1111, 1'b0);
        cyc("R7", 1'b1, 3'b011, 1'b0, 2'b00, 8'd62, 18'h1_1111, 1'b0);
        cyc("R7", 1'b1, 3'b000, 1'b1, 2'b11, 8'd60, '0, 1'b0);
        idle("R7"); idle("R7");
        rd("R7", 8'd60); rd("R7", 8'd61); rd("R7", 8'd62);
        idle("R7"); idle("R7");
    endtask

    task automatic t_hold();
        rd("R8", 8'd70);
        cyc("R8", 1'b0, 3'b010, 1'b0, 2'b00, 8'd70, 18'h2_BEEF, 1'b0);
        cyc("R8", 1'b0, 3'b010, 1'b0, 2'b00, 8'd70, 18'h2_BEEF, 1'b0);
        wr("R8", 8'd71, 2'b00, 18'h1_CAFE);
        cyc("R8", 1'b0, 3'b010, 1'b1, 2'b11, 8'd72, '0, 1'b0);
        cyc("R8", 1'b0, 3'b010, 1'b1, 2'b11, 8'd72, '0, 1'b0);
        rd("R8", 8'd71);
        cyc("R8", 1'b0, 3'b010, 1'b1, 2'b11, 8'd73, '0, 1'b0);
        rd("R8", 8'd70);
        idle("R8"); idle("R8");
    endtask

    task automatic t_oe();
        rd("R9", 8'd80);
        rd("R9", 8'd81);
        oe_n = 1'b1;
        #1;
        chk("R9", "pipelined", p_oe, 1'b0, p_dout, '0);
        chk("R9", "flow", f_oe, 1'b0, f_dout, '0);
        oe_n = 1'b0;
        #1;
        chk("R9", "pipelined", p_oe, exp_p_oe, p_dout, exp_p_d);
        chk("R9", "flow", f_oe, exp_f_oe, f_dout, exp_f_d);
        idle("R9"); idle("R9");
    endtask

    task automatic t_sleep();
        cyc("R10", 1'b1, 3'b010, 1'b0, 2'b00, 8'd90, 18'h3_1234, 1'b1);
        cyc("R10", 1'b1, 3'b010, 1'b1, 2'b11, 8'd91, '0, 1'b1);
        idle("R10"); idle("R10");
        rd("R10", 8'd90);
        idle("R10"); idle("R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_p[i] = '0;
            ref_f[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_reads();
        t_mixed();
        t_bytes();
        t_desel();
        t_hold();
        t_oe();
        t_sleep();
        finish_run();
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule